// File: doc/BRIEF.md
# Register File with Constant-Zero Top Register

This block holds the general-purpose registers of a single-cycle processor. It has two read ports and one write port. The read ports are combinational: a data output follows its address inputs in the same cycle. The write port updates one register on the rising clock edge. The highest register index always reads as zero. Writes aimed at it are dropped, so software can use that index as a zero source and as a discard destination.

Three address fields come from the instruction: `ra_addr`, `rb_addr` and `rc_addr`. Port A always reads the register at `ra_addr`. Port B reads either `rb_addr` or `rc_addr`, chosen by `b_from_rc`. This lets a store instruction read its source value through port B using the destination field. Writes always target `rc_addr`. The contents are undefined after power-up.

Top module: `zrf_regfile`

## Requirements
- R1: With `wr_en` low, `a_data` equals the value last written to register `ra_addr`, in the same cycle the address is applied.
- R2: On either read port, the address 5'b11111 (index 31) returns 32'h0, whatever was written to that index.
- R3: Port B reads register `rc_addr` when `b_from_rc` is 1 and register `rb_addr` when it is 0.
- R4: A rising clock edge with `wr_en` high stores `wr_data` into register `rc_addr`. An edge with `wr_en` low changes no register.
- R5: A write addressed to index 31 is discarded. Index 31 still reads zero, and every other register keeps its value.
- R6: While a write to register N is pending in a cycle, a read of N returns the old value. The new value appears only after the rising edge.
- R7: Ports A and B read any two registers at once without affecting each other, including when both read the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| wr_en | input | 1 | Write enable for the write port |
| ra_addr | input | 5 | Port A read address |
| rb_addr | input | 5 | Port B address when `b_from_rc` is 0 |
| rc_addr | input | 5 | Write address; port B address when `b_from_rc` is 1 |
| b_from_rc | input | 1 | Port B address select: 1 = `rc_addr`, 0 = `rb_addr` |
| wr_data | input | 32 | Data to write |
| a_data | output | 32 | Port A read data |
| b_data | output | 32 | Port B read data |

## Verification
Storage state can only be seen through the read ports, and those are combinational, so a corrupted or missed write shows up the moment any port addresses the affected row. A wrong row enable, such as a write leaking into the wrong register or index 31 becoming writable, therefore shows on the first read after the faulty clock edge. To expose such faults, the bench fills every register with a distinct pattern. It then sweeps both ports across all address pairs and rechecks every register after each special write. A swapped port B select or a missing zero override shows within the same cycle as the address that triggers it.

// File: rtl/zrf_pkg.sv
package zrf_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 5;

    typedef enum logic {
        BSRC_RB = 1'b0,
        BSRC_RC = 1'b1
    } bsrc_e;
endpackage

// File: rtl/zrf_bsel.sv
module zrf_bsel #(
    parameter int unsigned ADDR_W = zrf_pkg::DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic [ADDR_W-1:0] rc_addr,
    input  logic              sel,
    output logic [ADDR_W-1:0] b_addr
);
    import zrf_pkg::*;

    bsrc_e src;

    always_comb begin
        src = bsrc_e'(sel);
        unique case (src)
            BSRC_RC: b_addr = rc_addr;
            default: b_addr = rb_addr;
        endcase
    end
endmodule

// File: rtl/zrf_wdec.sv
module zrf_wdec #(
    parameter int unsigned ADDR_W = zrf_pkg::DEF_ADDR_W,
    parameter int unsigned NSTORE = (1 << ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NSTORE-1:0] row_we
);
    localparam int unsigned NREGS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(NREGS - 1);

    for (genvar i = 0; i < NSTORE; i++) begin : g_row
        assign row_we[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    // Checks sampled at the edge, when the write actually commits
    always_ff @(posedge clk) begin
        assert_onehot_we_R4: assert ($onehot0(row_we))
            else $error("more than one row enabled");
        if (wr_en === 1'b0)
            assert_idle_no_we_R4: assert (row_we == '0)
                else $error("row enabled without wr_en");
        if (wr_addr === TOP_IDX)
            assert_top_discard_R5: assert (row_we == '0)
                else $error("write to zero index reached storage");
    end
endmodule

// File: rtl/zrf_store.sv
module zrf_store #(
    parameter int unsigned DATA_W = zrf_pkg::DEF_DATA_W,
    parameter int unsigned NSTORE = 31
) (
    input  logic                           clk,
    input  logic [NSTORE-1:0]              row_we,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NSTORE-1:0][DATA_W-1:0]  rows
);
    typedef struct packed {
        logic [NSTORE-1:0][DATA_W-1:0] row;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(NSTORE); i++) begin
            if (row_we[i]) st_d.row[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rows = st_q.row;
endmodule

// File: rtl/zrf_rdport.sv
module zrf_rdport #(
    parameter int unsigned DATA_W = zrf_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = zrf_pkg::DEF_ADDR_W,
    parameter int unsigned NSTORE = (1 << ADDR_W) - 1
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NSTORE-1:0][DATA_W-1:0]  rows,
    output logic [DATA_W-1:0]              data
);
    always_comb begin
        data = '0;
        for (int i = 0; i < int'(NSTORE); i++) begin
            if (addr == ADDR_W'(i)) data = rows[i];
        end
    end
endmodule

// File: rtl/zrf_regfile.sv
module zrf_regfile #(
    parameter int unsigned DATA_W = zrf_pkg::DEF_DATA_W,
    parameter int unsigned ADDR_W = zrf_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    input  logic [ADDR_W-1:0] rc_addr,
    input  logic              b_from_rc,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] a_data,
    output logic [DATA_W-1:0] b_data
);
    localparam int unsigned NREGS  = 1 << ADDR_W;
    localparam int unsigned NSTORE = NREGS - 1;
    localparam int unsigned NRD    = 2;
    localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(NREGS - 1);

    logic [ADDR_W-1:0]              b_addr;
    logic [NSTORE-1:0]              row_we;
    logic [NSTORE-1:0][DATA_W-1:0]  rows;
    logic [NRD-1:0][ADDR_W-1:0]     rd_addr;
    logic [NRD-1:0][DATA_W-1:0]     rd_data;

    zrf_bsel #(.ADDR_W(ADDR_W)) bsel_i (
        .rb_addr (rb_addr),
        .rc_addr (rc_addr),
        .sel     (b_from_rc),
        .b_addr  (b_addr)
    );

    zrf_wdec #(.ADDR_W(ADDR_W), .NSTORE(NSTORE)) wdec_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (rc_addr),
        .row_we  (row_we)
    );

    zrf_store #(.DATA_W(DATA_W), .NSTORE(NSTORE)) store_i (
        .clk     (clk),
        .row_we  (row_we),
        .wr_data (wr_data),
        .rows    (rows)
    );

    assign rd_addr[0] = ra_addr;
    assign rd_addr[1] = b_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_port
        zrf_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSTORE(NSTORE)) rd_i (
            .addr (rd_addr[p]),
            .rows (rows),
            .data (rd_data[p])
        );
    end

    assign a_data = rd_data[0];
    assign b_data = rd_data[1];

    // Port-level checks, sampled at the edge while inputs are stable
    always_ff @(posedge clk) begin
        if (ra_addr === TOP_IDX)
            assert_zero_a_R2: assert (a_data === '0)
                else $error("port A index 31 not zero");
        if ((b_from_rc === 1'b1 && rc_addr === TOP_IDX) ||
            (b_from_rc === 1'b0 && rb_addr === TOP_IDX))
            assert_zero_b_R2: assert (b_data === '0)
                else $error("port B index 31 not zero");
        if (b_from_rc === 1'b1 && rc_addr === ra_addr)
            assert_bsel_rc_R3: assert (b_data === a_data)
                else $error("port B did not follow rc_addr");
        if (b_from_rc === 1'b0 && rb_addr === ra_addr)
            assert_bsel_rb_R7: assert (b_data === a_data)
                else $error("ports disagree on the same register");
    end
endmodule

// File: tb/zrf_regfile_tb.sv
`timescale 1ns/1ps
module zrf_regfile_tb_top;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  ra_addr = '0, rb_addr = '0, rc_addr = '0;
    logic        b_from_rc = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] a_data, b_data;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [32];

    always #(TCLK/2) clk = ~clk;

    zrf_regfile dut_i (
        .clk(clk), .wr_en(wr_en), .ra_addr(ra_addr), .rb_addr(rb_addr),
        .rc_addr(rc_addr), .b_from_rc(b_from_rc), .wr_data(wr_data),
        .a_data(a_data), .b_data(b_data)
    );

    function automatic logic [31:0] pat(input int i, input int k);
        return (32'h5A3C_0F00 ^ (32'(i) * 32'h0101_0101)) + 32'(k) * 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] expect_rd(input int a);
        return (a == 31) ? 32'h0 : model[a];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        rc_addr = 5'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a != 31) model[a] = d;
    endtask

    task automatic sweep_a(input string req);
        for (int a = 0; a < 32; a++) begin
            ra_addr = 5'(a); #1;
            check(req, a_data, expect_rd(a));
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 'x;
        @(negedge clk);
        // power-up: index 31 reads zero before any write
        ra_addr = 5'd31; rb_addr = 5'd31; b_from_rc = 1'b0; #1;
        check("R2 initial A", a_data, 32'h0);
        check("R2 initial B", b_data, 32'h0);

        // R4: fill every index, including 31
        for (int i = 0; i < 32; i++) wr(i, pat(i, 0));
        sweep_a("R1/R4 fill");

        // R3: B source select, with the other field pointing elsewhere
        for (int a = 0; a < 32; a++) begin
            b_from_rc = 1'b0; rb_addr = 5'(a); rc_addr = 5'(31 - a); #1;
            check("R3 sel=rb", b_data, expect_rd(a));
            b_from_rc = 1'b1; rb_addr = 5'(31 - a); rc_addr = 5'(a); #1;
            check("R3 sel=rc", b_data, expect_rd(a));
        end

        // R7: every pair of addresses on both ports
        b_from_rc = 1'b0;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                ra_addr = 5'(a); rb_addr = 5'(b); #1;
                check("R7 pair A", a_data, expect_rd(a));
                check("R7 pair B", b_data, expect_rd(b));
            end
        end

        // R4: an edge with wr_en low changes nothing
        @(negedge clk);
        rc_addr = 5'd7; wr_data = 32'hDEAD_BEEF; wr_en = 1'b0;
        @(negedge clk);
        sweep_a("R4 wr_en low");

        // R6: read of the register being written returns the old value
        @(negedge clk);
        rc_addr = 5'd9; wr_data = 32'hCAFE_0009; wr_en = 1'b1; ra_addr = 5'd9; #1;
        check("R6 before edge", a_data, model[9]);
        @(posedge clk); #1;
        check("R6 after edge", a_data, 32'hCAFE_0009);
        @(negedge clk);
        wr_en = 1'b0;
        model[9] = 32'hCAFE_0009;

        // R5: write to index 31 discarded, others untouched
        wr(31, 32'hFFFF_FFFF);
        ra_addr = 5'd31; b_from_rc = 1'b1; rc_addr = 5'd31; #1;
        check("R5 A zero", a_data, 32'h0);
        check("R5 B zero", b_data, 32'h0);
        b_from_rc = 1'b0;
        sweep_a("R5 others kept");

        // second pattern: toggles stored bits, then complement
        for (int i = 0; i < 32; i++) wr(i, pat(i, 1));
        sweep_a("R1/R4 pattern 2");
        for (int i = 0; i < 32; i++) wr(i, ~pat(i, 1));
        sweep_a("R1/R4 pattern 3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(TCLK * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog got=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule